// File: doc/BRIEF.md
# Windowed Service Watchdog with Early-Warning Interrupt

This block watches a processor's service pulses and forces a reset when software stops servicing it properly. A service pulse must arrive inside a window: not before a programmable minimum elapsed count, and not later than a programmable maximum. A pulse that comes too soon is treated as a fault and starts the reset pulse at once. A missed deadline first raises an interrupt, which gives software a last chance to react. A fixed grace period of 512 clock cycles follows. If software still does not service the block, a reset pulse of programmable width is driven.

After power-on reset, and after every reset pulse it generates, the block runs a longer startup timeout. During startup the minimum-window check is skipped, so a boot loader may service the block as early as it likes. A disable input freezes the timer, masks the interrupt and keeps any new reset from starting.

Threshold and width settings are captured only while the block is disabled or driving its reset pulse. Changing them while the block is enabled therefore cannot shorten the window that is already running.

Top module: `svc_watchdog`

## Requirements
- R1: In the run phase, a service event with elapsed count `n` (clock edges since the previous accepted event) where min <= n <= max is accepted. The count restarts from zero, and the next deadline is measured from that edge.
- R2: In the run phase, a service event with n < min is a fault. `wd_rst_o` is high from the next clock edge, and `irq_o` stays low.
- R3: With no service event, `irq_o` rises on the (max+1)-th enabled clock edge after the last accepted event.
- R4: Once `irq_o` has risen, and if no service event comes, `wd_rst_o` rises and `irq_o` falls on the 512th enabled clock edge after `irq_o` rose.
- R5: A service event during the grace period drops `irq_o`, cancels the pending reset and restarts the run-phase timing from that edge.
- R6: After `rst_n` is released, and after each reset pulse ends, the startup phase applies. Its deadline is boot+1 enabled edges, and a service event at any count is accepted without a window check.
- R7: While `dis_i` is high, the elapsed count and phase are frozen, `irq_o` is low, service events are ignored and no reset pulse starts.
- R8: The reset pulse lasts `pw` clock cycles, with a value of 0 treated as 1. The startup phase follows it.
- R9: A service event is a rising edge of `svc_i`. A level held high for several cycles counts once.
- R10: Threshold and width inputs take effect only when captured on an edge where `dis_i` is high or the reset pulse is active. On `rst_n` the captured values are the parameter defaults.
- R11: `irq_o` and `wd_rst_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_i | input | 1 | Service (kick) input, rising edge counts |
| dis_i | input | 1 | Freeze and mask the watchdog while high |
| win_lo_i | input | CNT_W | Minimum elapsed count for an accepted service |
| win_hi_i | input | CNT_W | Maximum elapsed count before the interrupt |
| boot_lim_i | input | CNT_W | Startup-phase deadline |
| pw_i | input | PW_W | Reset pulse width in cycles (0 means 1) |
| irq_o | output | 1 | Early-warning interrupt |
| wd_rst_o | output | 1 | Reset pulse to the processor |

## Verification
The bench sweeps the service gap over every count from 1 to max with small thresholds. A design with an off-by-one window edge would either fault on a legal gap of exactly min or accept a gap of min-1. It measures the startup, run and grace deadlines to the exact edge, and it sweeps the pulse width across 0 to 3, so a wrong counter compare, or a zero width that locks the pulse on, shows up as a shifted edge. It holds the service input high across several edges to catch a level-sensitive kick, which would fault at once. It also reprograms the maximum while the block is enabled, to catch a design that lets live inputs cut short the running window.

// File: rtl/svc_wd_pkg.sv
package svc_wd_pkg;
  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,
    PH_RUN   = 2'd1,
    PH_GRACE = 2'd2,
    PH_PULSE = 2'd3
  } wd_phase_e;

  // service event counted too early for the window
  function automatic logic too_early(input int unsigned elapsed, input int unsigned lo);
    return elapsed < lo;
  endfunction

  // effective reset pulse length: zero maps to one cycle
  function automatic int unsigned pulse_cycles(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction
endpackage

// File: rtl/svc_wd_edge.sv
module svc_wd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/svc_wd_cfg.sv
module svc_wd_cfg #(
  parameter int CNT_W  = 16,
  parameter int PW_W   = 8,
  parameter int LO_DEF = 4,
  parameter int HI_DEF = 1000,
  parameter int BT_DEF = 4000,
  parameter int PW_DEF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] bt_i,
  input  logic [PW_W-1:0]  pw_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] bt_o,
  output logic [PW_W-1:0]  pw_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_o <= CNT_W'(LO_DEF);
      hi_o <= CNT_W'(HI_DEF);
      bt_o <= CNT_W'(BT_DEF);
      pw_o <= PW_W'(PW_DEF);
    end else if (cap_i) begin
      lo_o <= lo_i;
      hi_o <= hi_i;
      bt_o <= bt_i;
      pw_o <= pw_i;
    end
  end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import svc_wd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PW_W      = 8,
  parameter int GRACE_CYC = 512,
  parameter int LO_DEF    = 4,
  parameter int HI_DEF    = 1000,
  parameter int BT_DEF    = 4000,
  parameter int PW_DEF    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_i,
  input  logic             dis_i,
  input  logic [CNT_W-1:0] win_lo_i,
  input  logic [CNT_W-1:0] win_hi_i,
  input  logic [CNT_W-1:0] boot_lim_i,
  input  logic [PW_W-1:0]  pw_i,
  output logic             irq_o,
  output logic             wd_rst_o
);
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_CYC - 1);

  wd_phase_e        ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_c, hi_c, bt_c;
  logic [PW_W-1:0]  pw_c;
  logic [CNT_W-1:0] pulse_last;

  // named internal events
  logic svc_ev;
  logic cfg_cap;
  logic early_fault;
  logic run_timeout;
  logic boot_timeout;
  logic grace_done;
  logic pulse_done;

  svc_wd_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (svc_i),
    .rise_o (svc_ev)
  );

  assign cfg_cap = dis_i | (ph_q == PH_PULSE);

  svc_wd_cfg #(
    .CNT_W (CNT_W), .PW_W (PW_W),
    .LO_DEF(LO_DEF), .HI_DEF(HI_DEF), .BT_DEF(BT_DEF), .PW_DEF(PW_DEF)
  ) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cfg_cap),
    .lo_i  (win_lo_i),
    .hi_i  (win_hi_i),
    .bt_i  (boot_lim_i),
    .pw_i  (pw_i),
    .lo_o  (lo_c),
    .hi_o  (hi_c),
    .bt_o  (bt_c),
    .pw_o  (pw_c)
  );

  assign pulse_last   = CNT_W'(pulse_cycles(32'(pw_c)) - 1);
  assign early_fault  = (ph_q == PH_RUN) && !dis_i && svc_ev && too_early(32'(cnt_q), 32'(lo_c));
  assign run_timeout  = (ph_q == PH_RUN) && !dis_i && !svc_ev && (cnt_q == hi_c);
  assign boot_timeout = (ph_q == PH_BOOT) && !dis_i && !svc_ev && (cnt_q == bt_c);
  assign grace_done   = (ph_q == PH_GRACE) && !dis_i && !svc_ev && (cnt_q == GRACE_LAST);
  assign pulse_done   = (ph_q == PH_PULSE) && (cnt_q == pulse_last);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_BOOT: if (!dis_i) begin
        if (svc_ev)            begin ph_d = PH_RUN;   cnt_d = '0; end
        else if (boot_timeout) begin ph_d = PH_GRACE; cnt_d = '0; end
        else                   cnt_d = cnt_q + 1'b1;
      end
      PH_RUN: if (!dis_i) begin
        if (early_fault)       begin ph_d = PH_PULSE; cnt_d = '0; end
        else if (svc_ev)       cnt_d = '0;
        else if (run_timeout)  begin ph_d = PH_GRACE; cnt_d = '0; end
        else                   cnt_d = cnt_q + 1'b1;
      end
      PH_GRACE: if (!dis_i) begin
        if (svc_ev)            begin ph_d = PH_RUN;   cnt_d = '0; end
        else if (grace_done)   begin ph_d = PH_PULSE; cnt_d = '0; end
        else                   cnt_d = cnt_q + 1'b1;
      end
      PH_PULSE: begin
        if (pulse_done)        begin ph_d = PH_BOOT;  cnt_d = '0; end
        else                   cnt_d = cnt_q + 1'b1;
      end
      default: begin ph_d = PH_BOOT; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_BOOT;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign irq_o    = (ph_q == PH_GRACE) && !dis_i;
  assign wd_rst_o = (ph_q == PH_PULSE);

  // R2: early service enters the reset pulse on the next edge, no interrupt
  a_r2_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    early_fault |=> (wd_rst_o && !irq_o));

  // R1: accepted run-phase service restarts count in run phase
  a_r1_accept_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_RUN) && svc_ev && !dis_i && !early_fault) |=> (cnt_q == '0 && ph_q == PH_RUN));

  // R5: service during grace cancels the pending reset
  a_r5_grace_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_GRACE) && svc_ev && !dis_i) |=> (!wd_rst_o && !irq_o));

  // R4: reset pulse only starts from grace expiry or an early fault
  a_r4_pulse_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_o) |-> ($past(grace_done) || $past(early_fault)));

  // R7: disable freezes count and phase outside the pulse, masks interrupt
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_i && ph_q != PH_PULSE) |=> ($stable(cnt_q) && $stable(ph_q)));
  a_r7_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    dis_i |-> !irq_o);

  // R10: captured thresholds hold while enabled and outside the pulse
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cap |=> ($stable(lo_c) && $stable(hi_c) && $stable(bt_c) && $stable(pw_c)));

  // R11: outputs exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && wd_rst_o));
endmodule

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;
  localparam int CLK_PER = 10;
  localparam int CW = 16;
  localparam int PWW = 8;
  localparam int GRACE = 512;
  localparam int LO = 4;
  localparam int HI = 20;
  localparam int BT = 60;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n, svc, dis;
  logic [CW-1:0] lo_v, hi_v, bt_v;
  logic [PWW-1:0] pw_v;
  logic irq, wrst;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  svc_watchdog u_svc_watchdog (
    .clk(clk), .rst_n(rst_n), .svc_i(svc), .dis_i(dis),
    .win_lo_i(lo_v), .win_hi_i(hi_v), .boot_lim_i(bt_v), .pw_i(pw_v),
    .irq_o(irq), .wd_rst_o(wrst)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick();
    svc = 1'b1;
    step(1);
    svc = 1'b0;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // R11 monitored on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (irq && wrst) begin
      errors++;
      $display("FAIL R11: irq=%0b rst=%0b expected not both", irq, wrst);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; svc = 1'b0; dis = 1'b1;
    lo_v = CW'(LO); hi_v = CW'(HI); bt_v = CW'(BT); pw_v = PWW'(PW);
    step(3);
    chk("R11 reset irq", irq, 1'b0);
    chk("R11 reset rst", wrst, 1'b0);
    rst_n = 1'b1;
    step(2);
    dis = 1'b0;

    // R6 startup deadline, R3 interrupt, R4 grace, R8 pulse
    step(BT);        chk("R6 boot before deadline", irq, 1'b0);
    step(1);         chk("R6 boot deadline irq", irq, 1'b1);
    step(GRACE - 1); chk("R4 grace irq held", irq, 1'b1);
                     chk("R4 grace no rst yet", wrst, 1'b0);
    step(1);         chk("R4 rst after grace", wrst, 1'b1);
                     chk("R4 irq drops", irq, 1'b0);
    step(PW - 1);    chk("R8 pulse still high", wrst, 1'b1);
    step(1);         chk("R8 pulse ended", wrst, 1'b0);

    // R6 early kick accepted in startup
    kick();          chk("R6 early boot kick accepted", wrst, 1'b0);

    // R1 / R2 gap sweep
    for (int g = 1; g <= HI; g++) begin
      step(g);
      kick();
      if (g < LO) begin
        chk("R2 early kick faults", wrst, 1'b1);
        chk("R2 no irq on fault", irq, 1'b0);
        step(PW);
        chk("R8 pulse over after fault", wrst, 1'b0);
        kick();
        chk("R6 boot kick after fault", wrst, 1'b0);
      end else begin
        chk("R1 in-window kick accepted", wrst, 1'b0);
        chk("R1 no irq", irq, 1'b0);
      end
    end

    // R3 run deadline
    step(HI);        chk("R3 before deadline", irq, 1'b0);
    step(1);         chk("R3 deadline irq", irq, 1'b1);

    // R5 kick in grace
    step(100);       chk("R5 irq in grace", irq, 1'b1);
    kick();          chk("R5 irq cleared", irq, 1'b0);
                     chk("R5 no reset", wrst, 1'b0);
    step(HI);        chk("R5 restart before deadline", irq, 1'b0);
    step(1);         chk("R5 restart deadline", irq, 1'b1);
    kick();

    // R9 held level counts once
    step(LO);
    svc = 1'b1;
    step(4);
    svc = 1'b0;
    chk("R9 held kick no fault", wrst, 1'b0);
    step(HI - 3);    chk("R9 timing from first edge", irq, 1'b0);
    step(1);         chk("R9 deadline from first edge", irq, 1'b1);
    kick();

    // R7 disable freezes and ignores kicks
    step(5);
    dis = 1'b1;
    step(50);        chk("R7 no irq while disabled", irq, 1'b0);
                     chk("R7 no rst while disabled", wrst, 1'b0);
    kick();
    step(1);
    dis = 1'b0;
    step(HI - 5);    chk("R7 count frozen before deadline", irq, 1'b0);
    step(1);         chk("R7 count frozen deadline", irq, 1'b1);
    dis = 1'b1;
    step(GRACE + 100);
                     chk("R7 grace irq masked", irq, 1'b0);
                     chk("R7 grace no reset", wrst, 1'b0);
    dis = 1'b0;
    step(1);         chk("R7 grace resumes", irq, 1'b1);
    kick();

    // R10 live change while enabled has no effect
    hi_v = CW'(8);
    step(HI);        chk("R10 old max still used", irq, 1'b0);
    step(1);         chk("R10 old max deadline", irq, 1'b1);
    kick();
    dis = 1'b1; step(1); dis = 1'b0;
    step(8);         chk("R10 new max before deadline", irq, 1'b0);
    step(1);         chk("R10 new max deadline", irq, 1'b1);
    kick();

    // R8 width sweep, zero maps to one
    for (int w = 0; w <= 3; w++) begin
      dis = 1'b1; pw_v = PWW'(w); step(1); dis = 1'b0;
      kick();
      chk("R8 pulse starts", wrst, 1'b1);
      step(((w == 0) ? 1 : w) - 1);
      chk("R8 pulse width held", wrst, 1'b1);
      step(1);
      chk("R8 pulse width end", wrst, 1'b0);
      kick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule